// File: doc/BRIEF.md
# Four-Way Write-Back Cache Controller

This block is a 4-way set-associative data cache for a core with 64-bit byte addresses. The address is cut into a 6-bit line offset, a 9-bit set index and a 49-bit tag, which gives 512 sets of 64-byte lines. Each way keeps its own tag, a valid flag, a dirty flag and one parity bit. Each set also keeps three tree pseudo-LRU bits. A lookup compares all four tags of the indexed set at the same time. A hit is answered from the line array. A miss picks a victim, writes the victim back to memory if it is dirty, and then refills the line. Write hits update only the cache and mark the line dirty. Write misses allocate the line first and then merge the new word into it.

The core side moves one 64-bit word per request. The word is chosen by address bits [5:3], and bits [2:0] are ignored. Requests use a valid/ready handshake. `core_req_ready` is high only when the controller is idle, initialisation is over and no earlier response is still waiting. Responses also use valid/ready: a response stays valid with stable hit and data until `core_rsp_ready` takes it. The memory side moves whole 512-bit lines. A request there holds its valid, address, direction and write line unchanged until `mem_req_ready`. A refill line is taken only in a cycle where `mem_rsp_ready` is high.

Memory sends a parity bit with each refill. A clean line whose stored parity does not agree with its data counts as a miss. It is fetched again into the same way and no error is signalled.

Top module: `assoc_cache_ctrl`

## Requirements
- R1: The address is split as offset [5:0], set index [14:6] and tag [63:15]. The returned word is bits [64k+63:64k] of the line, where k is address bits [5:3]. A memory line address is {tag, set, 6'b0}. Two addresses that differ only in the top tag bit are different lines.
- R2: During reset, `core_req_ready`, `busy`, `mem_req_valid` and `core_rsp_valid` are all low. After reset is released, `core_req_ready` stays low for at least 512 cycles while every valid and dirty bit is cleared. After that, every first access to a line misses.
- R3: A read whose tag matches a valid way of its set answers with `core_rsp_hit`=1 and the stored word, and causes no memory traffic.
- R4: A read miss issues one memory read (`mem_req_write`=0) for the line. It then answers with `core_rsp_hit`=0 and the requested word of the refilled line.
- R5: A write hit stores the word in the cache and marks the line dirty, without any memory write. Later reads of that line return the new word.
- R6: A write miss refills the line from memory and then merges the written word into it. The line becomes dirty. The response has hit=0 and echoes the written word. The rest of the line holds the memory contents.
- R7: The victim is chosen in this order: the way whose parity failed, then the lowest-numbered invalid way, then the way selected by the 3-bit tree pseudo-LRU. In the tree, the root bit picks between way pair {0,1} and pair {2,3}, and a second bit picks within the chosen pair, with 1 meaning the higher side. Every hit or refill sets the bits on its path to point away from the way just used.
- R8: A dirty victim is written back first, with `mem_req_write`=1, the victim's own line address and its full line, before the refill read. A clean victim is replaced with no write.
- R9: The stored parity is the bit that memory supplied, adjusted by the parity change of any merged word. A clean line whose parity bit differs from the XOR of its 512 data bits is treated as a miss and read again from memory. The read after that hits.
- R10: Parity is not checked on dirty lines. A dirty line with a parity mismatch still hits.
- R11: `busy` is high from the cycle after a miss is detected until the refill is accepted. While `busy` is high, `core_req_ready` is low.
- R12: While a memory request is not yet accepted, the memory request signals stay stable. While a response waits for `core_rsp_ready`, it stays valid with unchanged hit and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core request valid |
| core_req_ready | output | 1 | Controller can accept a request |
| core_req_write | input | 1 | 1 = write, 0 = read |
| core_req_addr | input | 64 | Byte address |
| core_req_wdata | input | 64 | Word to write |
| core_rsp_valid | output | 1 | Response valid |
| core_rsp_ready | input | 1 | Core takes the response |
| core_rsp_hit | output | 1 | 1 if the request hit |
| core_rsp_rdata | output | 64 | Read word, or the written word for writes |
| busy | output | 1 | Miss handling in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = writeback, 0 = line read |
| mem_req_addr | output | 64 | Line-aligned address |
| mem_req_wdata | output | 512 | Line being written back |
| mem_rsp_valid | input | 1 | Refill line valid |
| mem_rsp_ready | output | 1 | Controller accepts a refill line |
| mem_rsp_rdata | input | 512 | Refill line |
| mem_rsp_parity | input | 1 | Parity bit that comes with the refill line |

## Verification
The hardest case to reach from the ports is a clean line that holds a parity error, because the stored bits cannot be changed directly. The bench's memory model reaches it by sending one refill with an inverted parity bit. The bench then checks three things: the next read of that line misses and causes a new memory read, the read after that hits, and a written (dirty) line carrying the same fault keeps hitting. The pseudo-LRU order is reached by filling one set in a known sequence and touching way 0 again. Once the set is full, a clean victim and then a dirty victim are evicted, so both writeback-free replacement and writeback are checked at exact addresses.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_WB,
    S_FREQ,
    S_FWAIT
  } ctc_state_e;
endpackage

// File: rtl/ctc_way_match.sv
module ctc_way_match #(
  parameter int TAG_W = 49,
  parameter int WAYS  = 4
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0]            way_dirty,
  input  logic [WAYS-1:0]            way_par_ok,
  input  logic [TAG_W-1:0]           look_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic [WAYS-1:0]            bad_vec
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic eq;
    assign eq         = way_valid[w] && (way_tag[w] == look_tag);
    assign hit_vec[w] = eq && (way_dirty[w] || way_par_ok[w]);
    assign bad_vec[w] = eq && !way_dirty[w] && !way_par_ok[w];
  end
endmodule

// File: rtl/ctc_plru.sv
module ctc_plru #(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  bits_q,
  input  logic [WAYS-1:0]  valid,
  input  logic [WAYS-1:0]  bad,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim,
  output logic [WAYS-2:0]  bits_next
);
  // Heap-numbered tree: node 1 is the root, leaves are WAYS..2*WAYS-1.
  always_comb begin
    logic [WAY_W:0] node;
    node = (WAY_W+1)'(1);
    for (int l = 0; l < WAY_W; l++)
      node = {node[WAY_W-1:0], bits_q[node[WAY_W-1:0] - WAY_W'(1)]};
    victim = node[WAY_W-1:0];
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid[w]) victim = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (bad[w]) victim = WAY_W'(w);
  end

  always_comb begin
    logic [WAY_W:0] n;
    logic [WAY_W:0] p;
    bits_next = bits_q;
    n = {1'b1, touch_way};
    for (int l = 0; l < WAY_W; l++) begin
      p = n >> 1;
      bits_next[p[WAY_W-1:0] - WAY_W'(1)] = ~n[0];
      n = p;
    end
  end
endmodule

// File: rtl/assoc_cache_ctrl.sv
module assoc_cache_ctrl #(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 6,
  parameter int SET_W  = 9,
  parameter int WAYS   = 4,
  parameter int WORD_W = 64,
  localparam int LINE_W = 8 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic              core_req_write,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [WORD_W-1:0] core_req_wdata,
  output logic              core_rsp_valid,
  input  logic              core_rsp_ready,
  output logic              core_rsp_hit,
  output logic [WORD_W-1:0] core_rsp_rdata,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [LINE_W-1:0] mem_rsp_rdata,
  input  logic              mem_rsp_parity
);
  import ctc_pkg::*;

  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int SETS   = 1 << SET_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int WPL    = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WPL);
  localparam int BYTE_W = OFF_W - WSEL_W;
  localparam int RA_W   = ADDR_W - BYTE_W;

  // storage
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [LINE_W-1:0] data_q  [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [WAYS-1:0]   par_q   [SETS];
  logic [WAYS-2:0]   plru_q  [SETS];

  ctc_state_e        state_q;
  logic              init_q;
  logic [SET_W-1:0]  init_cnt_q;
  logic [RA_W-1:0]   req_addr_q;
  logic              req_write_q;
  logic [WORD_W-1:0] req_wdata_q;
  logic [WAY_W-1:0]  vic_q;
  logic              rsp_valid_q, rsp_hit_q;
  logic [WORD_W-1:0] rsp_data_q;

  logic unused_byte_lane;
  assign unused_byte_lane = ^core_req_addr[BYTE_W-1:0];

  logic [TAG_W-1:0]  r_tag;
  logic [SET_W-1:0]  r_set;
  logic [WSEL_W-1:0] r_wsel;
  assign r_tag  = req_addr_q[RA_W-1 -: TAG_W];
  assign r_set  = req_addr_q[WSEL_W +: SET_W];
  assign r_wsel = req_addr_q[WSEL_W-1:0];

  // parallel lookup of the indexed set
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic [WAYS-1:0]            par_ok, cur_valid, cur_dirty, cur_par;
  logic [WAYS-1:0]            hit_vec, bad_vec;
  assign cur_valid = valid_q[r_set];
  assign cur_dirty = dirty_q[r_set];
  assign cur_par   = par_q[r_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign way_tag[w] = tag_q[r_set][w];
    assign par_ok[w]  = (^data_q[r_set][w]) == cur_par[w];
  end

  ctc_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
    .way_tag(way_tag), .way_valid(cur_valid), .way_dirty(cur_dirty),
    .way_par_ok(par_ok), .look_tag(r_tag), .hit_vec(hit_vec), .bad_vec(bad_vec)
  );

  logic             any_hit;
  logic [WAY_W-1:0] hit_way, acc_way, victim;
  logic [WAYS-2:0]  plru_next;
  assign any_hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign acc_way = (state_q == S_LOOK) ? hit_way : vic_q;

  ctc_plru #(.WAYS(WAYS)) u_plru (
    .bits_q(plru_q[r_set]), .valid(cur_valid), .bad(bad_vec),
    .touch_way(acc_way), .victim(victim), .bits_next(plru_next)
  );

  // word merge and incremental parity
  logic [LINE_W-1:0] line_in, merged;
  logic [WORD_W-1:0] old_word, rsp_word;
  logic              par_in, par_new, dirty_new, upd_en;
  always_comb begin
    line_in  = (state_q == S_FWAIT) ? mem_rsp_rdata : data_q[r_set][hit_way];
    par_in   = (state_q == S_FWAIT) ? mem_rsp_parity : cur_par[hit_way];
    old_word = line_in[int'(r_wsel)*WORD_W +: WORD_W];
    merged   = line_in;
    if (req_write_q) merged[int'(r_wsel)*WORD_W +: WORD_W] = req_wdata_q;
    par_new  = par_in ^ (req_write_q & ((^old_word) ^ (^req_wdata_q)));
    rsp_word = req_write_q ? req_wdata_q : old_word;
    dirty_new = (state_q == S_LOOK) ? (cur_dirty[hit_way] | req_write_q) : req_write_q;
    upd_en   = ((state_q == S_LOOK) && any_hit) || ((state_q == S_FWAIT) && mem_rsp_valid);
  end

  // control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      init_q      <= 1'b1;
      init_cnt_q  <= '0;
      req_addr_q  <= '0;
      req_write_q <= 1'b0;
      req_wdata_q <= '0;
      vic_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (init_q) begin
        init_cnt_q <= init_cnt_q + SET_W'(1);
        if (init_cnt_q == SET_W'(SETS - 1)) init_q <= 1'b0;
      end
      if (rsp_valid_q && core_rsp_ready) rsp_valid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (core_req_valid && core_req_ready) begin
          req_addr_q  <= core_req_addr[ADDR_W-1:BYTE_W];
          req_write_q <= core_req_write;
          req_wdata_q <= core_req_wdata;
          state_q     <= S_LOOK;
        end
        S_LOOK: if (any_hit) begin
          rsp_valid_q <= 1'b1;
          rsp_hit_q   <= 1'b1;
          rsp_data_q  <= rsp_word;
          state_q     <= S_IDLE;
        end else begin
          vic_q   <= victim;
          state_q <= (cur_valid[victim] && cur_dirty[victim]) ? S_WB : S_FREQ;
        end
        S_WB:    if (mem_req_ready) state_q <= S_FREQ;
        S_FREQ:  if (mem_req_ready) state_q <= S_FWAIT;
        S_FWAIT: if (mem_rsp_valid) begin
          rsp_valid_q <= 1'b1;
          rsp_hit_q   <= 1'b0;
          rsp_data_q  <= rsp_word;
          state_q     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // arrays: sweep clear after reset, then one way updated per hit or refill
  always_ff @(posedge clk) begin
    if (init_q) begin
      valid_q[init_cnt_q] <= '0;
      dirty_q[init_cnt_q] <= '0;
      plru_q[init_cnt_q]  <= '0;
    end else if (upd_en) begin
      tag_q[r_set][acc_way]   <= r_tag;
      data_q[r_set][acc_way]  <= merged;
      par_q[r_set][acc_way]   <= par_new;
      valid_q[r_set][acc_way] <= 1'b1;
      dirty_q[r_set][acc_way] <= dirty_new;
      plru_q[r_set]           <= plru_next;
    end
  end

  assign core_req_ready = (state_q == S_IDLE) && !init_q && !rsp_valid_q;
  assign core_rsp_valid = rsp_valid_q;
  assign core_rsp_hit   = rsp_hit_q;
  assign core_rsp_rdata = rsp_data_q;
  assign busy           = (state_q == S_WB) || (state_q == S_FREQ) || (state_q == S_FWAIT);
  assign mem_req_valid  = (state_q == S_WB) || (state_q == S_FREQ);
  assign mem_req_write  = (state_q == S_WB);
  assign mem_req_addr   = {(state_q == S_WB) ? tag_q[r_set][vic_q] : r_tag, r_set, OFF_W'(0)};
  assign mem_req_wdata  = data_q[r_set][vic_q];
  assign mem_rsp_ready  = (state_q == S_FWAIT);
endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
  parameter int ADDR_W   = 64,
  parameter int WORD_W   = 64,
  parameter int INIT_CYC = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req_ready,
  input logic              core_rsp_valid,
  input logic              core_rsp_ready,
  input logic              core_rsp_hit,
  input logic [WORD_W-1:0] core_rsp_rdata,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready
);
  localparam int CNT_W = $clog2(INIT_CYC + 1);
  logic [CNT_W-1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != CNT_W'(INIT_CYC)) since_rst <= since_rst + CNT_W'(1);
  end

  // R2
  init_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_ready |-> (since_rst == CNT_W'(INIT_CYC)));

  // R11
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !core_req_ready);

  // R11
  mem_in_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  // R12
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rsp_valid && !core_rsp_ready) |=>
      (core_rsp_valid && $stable(core_rsp_hit) && $stable(core_rsp_rdata)));

  // R4
  fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready) |=> (core_rsp_valid && !core_rsp_hit));
endmodule

bind assoc_cache_ctrl ctc_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .INIT_CYC(1 << SET_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .core_req_ready(core_req_ready),
  .core_rsp_valid(core_rsp_valid), .core_rsp_ready(core_rsp_ready),
  .core_rsp_hit(core_rsp_hit), .core_rsp_rdata(core_rsp_rdata), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready)
);

// File: tb/assoc_cache_ctrl_tb_top.sv
module assoc_cache_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 512;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         core_req_valid = 1'b0, core_req_write = 1'b0, core_rsp_ready = 1'b0;
  logic [63:0]  core_req_addr = '0, core_req_wdata = '0;
  logic         core_req_ready, core_rsp_valid, core_rsp_hit, busy;
  logic [63:0]  core_rsp_rdata;
  logic         mem_req_valid, mem_req_write, mem_rsp_ready;
  logic [63:0]  mem_req_addr;
  logic [LINE_W-1:0] mem_req_wdata;
  logic         mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_parity = 1'b0;
  logic [LINE_W-1:0] mem_rsp_rdata = '0;

  assoc_cache_ctrl dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // reference contents seen by the core, and the backing store
  logic [63:0] ref_w [logic [63:0]];
  logic [63:0] mem_w [logic [63:0]];
  function automatic logic [63:0] pat(logic [63:0] wa);
    return (wa * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0F1E_2D3C_4B5A_6978;
  endfunction
  function automatic logic [63:0] ref_rd(logic [63:0] wa);
    return ref_w.exists(wa) ? ref_w[wa] : pat(wa);
  endfunction
  function automatic logic [63:0] mk(logic [48:0] t, int s, int w);
    return {t, s[8:0], w[2:0], 3'b000};
  endfunction

  typedef struct { bit hit; logic [63:0] data; string req; } exp_t;
  exp_t sb_q[$];

  // memory model
  int rd_cnt = 0, wb_cnt = 0;
  logic [63:0] last_rd_addr = '0, last_wb_addr = '0;
  logic [LINE_W-1:0] last_wb_line = '0;
  bit corrupt_next = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [63:0] a;
        logic wr;
        logic [LINE_W-1:0] ln;
        check(busy && !core_req_ready, "R11", "busy during memory request", {62'd0, busy, core_req_ready}, 64'd2);
        @(negedge clk);
        a = mem_req_addr; wr = mem_req_write; ln = mem_req_wdata;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (wr) begin
          wb_cnt++; last_wb_addr = a; last_wb_line = ln;
          for (int k = 0; k < 8; k++) mem_w[(a >> 3) + 64'(k)] = ln[k*64 +: 64];
        end else begin
          rd_cnt++; last_rd_addr = a;
          repeat (2) @(negedge clk);
          for (int k = 0; k < 8; k++) begin
            logic [63:0] wa;
            wa = (a >> 3) + 64'(k);
            ln[k*64 +: 64] = mem_w.exists(wa) ? mem_w[wa] : pat(wa);
          end
          mem_rsp_rdata  = ln;
          mem_rsp_parity = (^ln) ^ corrupt_next;
          corrupt_next   = 0;
          mem_rsp_valid  = 1'b1;
          while (!mem_rsp_ready) @(negedge clk);
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  // response back-pressure
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      c++;
      core_rsp_ready = (c % 3) != 1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit prev_wait = 0;
    logic [63:0] prev_data = '0;
    forever begin
      @(negedge clk);
      if (prev_wait)
        check(core_rsp_valid && core_rsp_rdata == prev_data, "R12", "response held", core_rsp_rdata, prev_data);
      prev_wait = rst_n && core_rsp_valid && !core_rsp_ready;
      prev_data = core_rsp_rdata;
      if (rst_n && core_rsp_valid && core_rsp_ready) begin
        if (sb_q.size() == 0) check(0, "R3", "unexpected response", core_rsp_rdata, 64'd0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          check(core_rsp_hit == e.hit, e.req, "hit flag", {63'd0, core_rsp_hit}, {63'd0, e.hit});
          check(core_rsp_rdata == e.data, e.req, "data", core_rsp_rdata, e.data);
        end
      end
    end
  end

  task automatic req(bit wr, logic [63:0] addr, logic [63:0] wd, bit exp_hit, string rq);
    exp_t e;
    e.hit = exp_hit;
    e.req = rq;
    e.data = wr ? wd : ref_rd(addr >> 3);
    if (wr) ref_w[addr >> 3] = wd;
    sb_q.push_back(e);
    @(posedge clk); #1;
    core_req_valid = 1'b1; core_req_write = wr; core_req_addr = addr; core_req_wdata = wd;
    do @(negedge clk); while (!core_req_ready);
    @(posedge clk); #1;
    core_req_valid = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R2", "watchdog expired", 64'd0, 64'd1);
    summary();
    $finish;
  end

  initial begin
    int cyc;
    int r0, w0;
    logic [48:0] big;
    big = {1'b1, 48'h7};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!core_req_ready && !busy && !mem_req_valid && !core_rsp_valid, "R2", "reset outputs",
          {60'd0, core_req_ready, busy, mem_req_valid, core_rsp_valid}, 64'd0);
    rst_n = 1'b1;
    cyc = 0;
    while (!core_req_ready) begin @(negedge clk); cyc++; end
    check(cyc >= 512 && cyc <= 520, "R2", "init cycles", 64'(cyc), 64'd512);

    // set 5: fill, hit, write-back, write-allocate, pseudo-LRU order
    req(0, mk(1, 5, 0), 0, 0, "R4");
    check(rd_cnt == 1, "R4", "one line read", 64'(rd_cnt), 64'd1);
    check(last_rd_addr == mk(1, 5, 0), "R1", "line address", last_rd_addr, mk(1, 5, 0));
    req(0, mk(1, 5, 3), 0, 1, "R3");
    check(rd_cnt == 1, "R3", "no read on hit", 64'(rd_cnt), 64'd1);
    req(1, mk(1, 5, 2), 64'hA5A5_0000_1111_2222, 1, "R5");
    req(0, mk(1, 5, 2), 0, 1, "R5");
    check(wb_cnt == 0, "R5", "no memory write on write hit", 64'(wb_cnt), 64'd0);
    req(1, mk(2, 5, 6), 64'hC0DE_0000_0000_0006, 0, "R6");
    req(0, mk(2, 5, 6), 0, 1, "R6");
    req(0, mk(2, 5, 7), 0, 1, "R6");
    req(0, mk(3, 5, 0), 0, 0, "R7");
    req(0, mk(4, 5, 1), 0, 0, "R7");
    req(0, mk(1, 5, 0), 0, 1, "R7");
    w0 = wb_cnt;
    req(0, mk(5, 5, 4), 0, 0, "R7");
    check(wb_cnt == w0, "R8", "clean victim no writeback", 64'(wb_cnt), 64'(w0));
    req(0, mk(3, 5, 0), 0, 0, "R7");
    check(wb_cnt == w0 + 1, "R8", "dirty victim written back", 64'(wb_cnt), 64'(w0 + 1));
    check(last_wb_addr == mk(2, 5, 0), "R8", "writeback address", last_wb_addr, mk(2, 5, 0));
    check(last_wb_line[6*64 +: 64] == 64'hC0DE_0000_0000_0006, "R8", "writeback word",
          last_wb_line[6*64 +: 64], 64'hC0DE_0000_0000_0006);
    req(0, mk(2, 5, 6), 0, 0, "R8");
    req(0, mk(1, 5, 2), 0, 1, "R7");
    req(0, mk(5, 5, 4), 0, 1, "R7");

    // top tag bit distinguishes lines
    req(0, mk(big, 300, 1), 0, 0, "R1");
    check(last_rd_addr == mk(big, 300, 0), "R1", "high tag address", last_rd_addr, mk(big, 300, 0));
    req(0, mk(49'h7, 300, 1), 0, 0, "R1");
    req(0, mk(big, 300, 5), 0, 1, "R1");

    // parity on clean and dirty lines
    corrupt_next = 1;
    req(0, mk(1, 7, 0), 0, 0, "R9");
    r0 = rd_cnt;
    req(0, mk(1, 7, 1), 0, 0, "R9");
    check(rd_cnt == r0 + 1, "R9", "refetch after parity error", 64'(rd_cnt), 64'(r0 + 1));
    req(0, mk(1, 7, 2), 0, 1, "R9");
    corrupt_next = 1;
    req(1, mk(2, 7, 3), 64'hDEAD_0000_BEEF_0003, 0, "R10");
    r0 = rd_cnt;
    req(0, mk(2, 7, 3), 0, 1, "R10");
    check(rd_cnt == r0, "R10", "dirty line not refetched", 64'(rd_cnt), 64'(r0));

    summary();
    $finish;
  end
endmodule